// File: doc/BRIEF.md
# GPIO Port Controller with Edge Interrupts

This block is a memory-mapped general-purpose I/O controller. Its pins are grouped into ports of eight. Each port has its own bank of seven registers on a simple 32-bit register bus. Through these registers software can:

- pick one of four drive modes for each pin;
- set the output levels and read the input levels;
- choose a falling or rising edge as a pin's interrupt trigger;
- mask, force and acknowledge the pin events;
- turn off a pin's pull-up.

Each port raises one level-sensitive interrupt line. Pin inputs pass through a two-flop synchroniser before they are read or edge-detected. One global control bit freezes every port bank. While it is clear, bank writes are dropped and no events are captured. Reads and the synchronisers keep working.

The pad cells take the per-pin output, output-enable and pull-up enable from this block. Pin multiplexing and bus bridging sit outside it.

Top module: `gpx_ctrl`

## Requirements
- R1: After reset, every pin has output enable low and pull-up enable high. Every interrupt line is low. Every register reads 0, the control register included.
- R2: Port p's bank starts at byte address p*0x1C. Within a bank, the offsets are: pin data +0x00, drive mode +0x04, event +0x08, interrupt enable +0x0C, force +0x10, edge select +0x14, pull-up disable +0x18. The control register is at 0x54, and bit 0 enables the block. Pin n maps to port n>>3 at bit n&7.
- R3: Reading pin data returns the input levels after two clock edges of synchronisation. Writing pin data sets the output latch. Reads never return the output latch.
- R4: The drive mode of pin k sits in bits [2k+1:2k] of the mode register. The modes are:
  - 0 (input): output enable low.
  - 1 (push-pull): output equals the data bit, output enable high.
  - 2 (open-drain): output low, output enable equal to the inverted data bit.
  - 3 (open-source): output high, output enable equal to the data bit.
- R5: An edge-select bit of 0 makes a falling edge of the synchronised input set that pin's event bit. A bit of 1 makes a rising edge set it. The opposite edge has no effect. The event bit is set on the third clock edge after the input changes.
- R6: Writing 1 to an event bit clears it. Writing 1 to a force bit sets the matching event bit at that same clock edge. The force register reads as 0.
- R7: A port's interrupt line is high exactly while some pin in that port has both its event bit and its enable bit set. Masking a pin leaves its event bit intact.
- R8: A pull-up-disable bit of 1 drives that pin's pull-up enable low.
- R9: While control bit 0 is 0, writes to the port banks are ignored and no edge or force sets an event. All bank state holds its value. Re-enabling the block does not create an event from input changes that happened while it was disabled.
- R10: Addresses that are unaligned or outside every bank and the control register read as 0. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| pin_in | input | 24 | Pad input levels |
| pin_out | output | 24 | Pad output levels |
| pin_oe | output | 24 | Pad output enables |
| pin_pull_en | output | 24 | Pad pull-up enables |
| irq | output | 3 | One level interrupt per port |

## Verification
Each bank is observable at the pins or through register reads one cycle after a write. A wrong drive-mode decode or output latch therefore shows on `pin_out`/`pin_oe` at the next sample. A broken event or enable register shows on `irq` at once. A synchroniser that is too short or too long moves the data readback and the event set by one cycle, so the bench samples both on the exact edge. A freeze that leaks while disabled shows as a changed pin, a readback change or a spurious event, either on the next read or on the first read after re-enabling.

// File: rtl/gpx_pkg.sv
// Shared definitions for the GPIO port controller.
// Assumes 8-pin ports and a 28-byte register stride per port.
package gpx_pkg;
    localparam int unsigned PORT_PINS   = 8;
    localparam int unsigned PORT_STRIDE = 28;

    typedef enum logic [1:0] {
        DRV_IN     = 2'd0,
        DRV_PUSH   = 2'd1,
        DRV_SINK   = 2'd2,
        DRV_SOURCE = 2'd3
    } drv_mode_e;

    typedef enum logic [2:0] {
        RG_DATA  = 3'd0,
        RG_MODE  = 3'd1,
        RG_EVT   = 3'd2,
        RG_IEN   = 3'd3,
        RG_FORCE = 3'd4,
        RG_EDGE  = 3'd5,
        RG_PUDIS = 3'd6
    } reg_idx_e;
endpackage

// File: rtl/gpx_sync.sv
// Two-flop input synchroniser, W bits wide.
// Assumes each bit is an independent level; no bus coherency is implied.
module gpx_sync #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Move pad levels through two stages into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/gpx_port.sv
// One 8-pin port: register bank, edge capture, interrupt merge, pad drive.
// Assumes pin_sync is already synchronised, and that wr_en is a decoded,
// aligned write to this bank.
module gpx_port
    import gpx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 blk_en,
    input  logic                 wr_en,
    input  logic [2:0]           reg_idx,
    input  logic [15:0]          wdata,
    input  logic [PORT_PINS-1:0] pin_sync,
    output logic [31:0]          rdata,
    output logic [PORT_PINS-1:0] pin_out,
    output logic [PORT_PINS-1:0] pin_oe,
    output logic [PORT_PINS-1:0] pull_en,
    output logic                 irq
);
    localparam int unsigned MW = 2 * PORT_PINS;

    logic [MW-1:0]        mode_q;
    logic [PORT_PINS-1:0] dout_q, evt_q, ien_q, edge_q, pud_q, prev_q;
    logic [PORT_PINS-1:0] wbyte, hit, evt_d;
    logic wr_data, wr_mode, wr_evt, wr_ien, wr_force, wr_edge, wr_pud;

    assign wbyte    = wdata[PORT_PINS-1:0];
    assign wr_data  = wr_en && blk_en && (reg_idx == RG_DATA);
    assign wr_mode  = wr_en && blk_en && (reg_idx == RG_MODE);
    assign wr_evt   = wr_en && blk_en && (reg_idx == RG_EVT);
    assign wr_ien   = wr_en && blk_en && (reg_idx == RG_IEN);
    assign wr_force = wr_en && blk_en && (reg_idx == RG_FORCE);
    assign wr_edge  = wr_en && blk_en && (reg_idx == RG_EDGE);
    assign wr_pud   = wr_en && blk_en && (reg_idx == RG_PUDIS);

    // Qualify edges of the synchronised input against the chosen polarity.
    always_comb begin
        hit = (edge_q & pin_sync & ~prev_q) | (~edge_q & ~pin_sync & prev_q);
        if (!blk_en) hit = '0;
    end

    // Next event state: a new set (edge or force) wins over an acknowledge.
    always_comb begin
        evt_d = evt_q;
        if (wr_evt)   evt_d = evt_d & ~wbyte;
        evt_d = evt_d | hit;
        if (wr_force) evt_d = evt_d | wbyte;
    end

    // Register bank and edge history; history always tracks the input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0; dout_q <= '0; evt_q <= '0; ien_q <= '0;
            edge_q <= '0; pud_q  <= '0; prev_q <= '0;
        end else begin
            prev_q <= pin_sync;
            evt_q  <= evt_d;
            if (wr_data) dout_q <= wbyte;
            if (wr_mode) mode_q <= wdata[MW-1:0];
            if (wr_ien)  ien_q  <= wbyte;
            if (wr_edge) edge_q <= wbyte;
            if (wr_pud)  pud_q  <= wbyte;
        end
    end

    // Per-pin pad drive from the mode field and the output latch.
    for (genvar k = 0; k < PORT_PINS; k++) begin : g_drv
        always_comb begin
            unique case (drv_mode_e'(mode_q[2*k +: 2]))
                DRV_PUSH:   begin pin_out[k] = dout_q[k]; pin_oe[k] = 1'b1;       end
                DRV_SINK:   begin pin_out[k] = 1'b0;      pin_oe[k] = ~dout_q[k]; end
                DRV_SOURCE: begin pin_out[k] = 1'b1;      pin_oe[k] = dout_q[k];  end
                default:    begin pin_out[k] = 1'b0;      pin_oe[k] = 1'b0;       end
            endcase
        end
    end

    assign pull_en = ~pud_q;
    assign irq     = |(evt_q & ien_q);

    // Read-back selection; force reads as zero.
    always_comb begin
        rdata = '0;
        case (reg_idx)
            RG_DATA:  rdata[PORT_PINS-1:0] = pin_sync;
            RG_MODE:  rdata[MW-1:0]        = mode_q;
            RG_EVT:   rdata[PORT_PINS-1:0] = evt_q;
            RG_IEN:   rdata[PORT_PINS-1:0] = ien_q;
            RG_EDGE:  rdata[PORT_PINS-1:0] = edge_q;
            RG_PUDIS: rdata[PORT_PINS-1:0] = pud_q;
            default:  rdata = '0;
        endcase
    end

    logic [PORT_PINS-1:0] sink_mask, in_mask;
    for (genvar k = 0; k < PORT_PINS; k++) begin : g_mask
        assign sink_mask[k] = (mode_q[2*k +: 2] == DRV_SINK);
        assign in_mask[k]   = (mode_q[2*k +: 2] == DRV_IN);
    end

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !blk_en |=> ($stable(mode_q) && $stable(dout_q) && $stable(evt_q) && $stable(ien_q))); // R9
    AST_FORCE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_force |=> ((evt_q & $past(wbyte)) == $past(wbyte))); // R6
    AST_SINK_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & pin_out & sink_mask) == '0); // R4
    AST_INPUT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & in_mask) == '0); // R4
endmodule

// File: rtl/gpx_ctrl.sv
// GPIO controller top: address decode, global enable, synchroniser and
// NUM_PORTS port banks. Assumes a single-cycle register bus; reads are
// combinational from the address while bus_sel is high.
module gpx_ctrl
    import gpx_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 3,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned CTRL_OFS  = 'h54,
    localparam int unsigned NPIN     = NUM_PORTS * PORT_PINS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NPIN-1:0]   pin_in,
    output logic [NPIN-1:0]   pin_out,
    output logic [NPIN-1:0]   pin_oe,
    output logic [NPIN-1:0]   pin_pull_en,
    output logic [NUM_PORTS-1:0] irq
);
    logic              en_q;
    logic              ctrl_hit;
    logic [NPIN-1:0]   pin_sync;
    logic [NUM_PORTS-1:0] hit;
    logic [31:0]       prd [NUM_PORTS];

    wire unused_wdata = ^bus_wdata[31:16];

    gpx_sync #(.W(NPIN)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
    );

    assign ctrl_hit = bus_sel && (int'(bus_addr) == int'(CTRL_OFS));

    // Global block enable, writable regardless of its own state.
    always_ff @(posedge clk) begin
        if (!rst_n)                en_q <= 1'b0;
        else if (ctrl_hit && bus_wr) en_q <= bus_wdata[0];
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        localparam int BASE = p * PORT_STRIDE;
        logic [ADDR_W-1:0] rel;
        logic              in_rng;
        wire unused_rel = ^{rel[ADDR_W-1:5]};

        assign rel    = bus_addr - ADDR_W'(BASE);
        assign in_rng = (int'(bus_addr) >= BASE) && (int'(bus_addr) < BASE + PORT_STRIDE);
        assign hit[p] = bus_sel && in_rng && (rel[1:0] == 2'b00);

        gpx_port u_port (
            .clk     (clk),
            .rst_n   (rst_n),
            .blk_en  (en_q),
            .wr_en   (hit[p] && bus_wr),
            .reg_idx (rel[4:2]),
            .wdata   (bus_wdata[15:0]),
            .pin_sync(pin_sync[p*PORT_PINS +: PORT_PINS]),
            .rdata   (prd[p]),
            .pin_out (pin_out[p*PORT_PINS +: PORT_PINS]),
            .pin_oe  (pin_oe[p*PORT_PINS +: PORT_PINS]),
            .pull_en (pin_pull_en[p*PORT_PINS +: PORT_PINS]),
            .irq     (irq[p])
        );
    end

    // Merge read data from whichever bank or control register is selected.
    always_comb begin
        bus_rdata = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (hit[p]) bus_rdata = bus_rdata | prd[p];
        end
        if (ctrl_hit) bus_rdata = bus_rdata | {31'b0, en_q};
    end

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctrl_hit, hit})); // R2
    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |-> (bus_rdata == '0)); // R10
endmodule

// File: tb/tb_gpx_ctrl.sv
// Directed bench for gpx_ctrl: one task per scenario, each checks itself.
module tb_gpx_ctrl;
    localparam int NP = 3;
    localparam int NPIN = NP * 8;

    logic clk = 1'b0;
    logic rst_n;
    logic bus_sel, bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic [NPIN-1:0] pin_in, pin_out, pin_oe, pin_pull_en;
    logic [NP-1:0] irq;
    int checks = 0;
    int errors = 0;
    logic [31:0] rv;

    always #4 clk = ~clk;

    gpx_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .pin_pull_en(pin_pull_en), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    // Expected {out, oe} of one pin from its mode and data bit (R4).
    function automatic logic [1:0] drv(input logic [1:0] m, input logic d);
        case (m)
            2'd1:    return {d, 1'b1};
            2'd2:    return {1'b0, ~d};
            2'd3:    return {1'b1, d};
            default: return 2'b00;
        endcase
    endfunction

    task automatic check_drive(input string req, input logic [15:0] m, input logic [7:0] d);
        logic [7:0] eo, ee;
        for (int k = 0; k < 8; k++) begin
            logic [1:0] r;
            r = drv(m[2*k +: 2], d[k]);
            eo[k] = r[1]; ee[k] = r[0];
        end
        chk(req, {24'b0, pin_oe[7:0]}, {24'b0, ee});
        for (int k = 0; k < 8; k++) if (ee[k]) chk(req, {31'b0, pin_out[k]}, {31'b0, eo[k]});
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 oe", {8'b0, pin_oe}, 32'h0);
        chk("R1 pull", {8'b0, pin_pull_en}, 32'h00FF_FFFF);
        chk("R1 irq", {29'b0, irq}, 32'h0);
        rd(8'h04, rv); chk("R1 mode0", rv, 0);
        rd(8'h54, rv); chk("R1 ctrl", rv, 0);
    endtask

    task automatic t_disabled_writes;
        wr(8'h04, 32'h5555);
        rd(8'h04, rv); chk("R9 write ignored", rv, 0);
        chk("R9 oe unchanged", {8'b0, pin_oe}, 0);
        wr(8'h54, 32'h1);
        rd(8'h54, rv); chk("R2 ctrl enable", rv, 1);
    endtask

    task automatic t_data;
        @(negedge clk); pin_in = 24'h3C_96_00;
        pin_in[7:0] = 8'h96; pin_in[15:8] = 8'h3C; pin_in[23:16] = 8'h00;
        @(posedge clk);
        rd(8'h1C, rv); chk("R3 one edge still old", rv, 0);
        @(posedge clk);
        rd(8'h1C, rv); chk("R3 port1 input", rv, 32'h3C);
        rd(8'h00, rv); chk("R3 port0 input", rv, 32'h96);
        wr(8'h00, 32'hAA);
        rd(8'h00, rv); chk("R3 read is input not latch", rv, 32'h96);
    endtask

    task automatic t_drive;
        wr(8'h04, 32'hE4E4);
        @(negedge clk); check_drive("R4 modes d=AA", 16'hE4E4, 8'hAA);
        wr(8'h00, 32'h55);
        @(negedge clk); check_drive("R4 modes d=55", 16'hE4E4, 8'h55);
        wr(8'h3C, 32'h5555); wr(8'h38, 32'hC3);
        @(negedge clk);
        chk("R2 R4 port2 push", {8'b0, pin_out[23:16], pin_oe[23:16]}, 32'h0000_C3FF);
    endtask

    task automatic t_edge;
        wr(8'h30, 32'h0F);
        wr(8'h24, 32'hFF);
        wr(8'h28, 32'hFF);
        rd(8'h24, rv); chk("R5 clean start", rv, 0);
        @(negedge clk); pin_in[15:8] = 8'h00;
        @(posedge clk); @(posedge clk);
        @(negedge clk); chk("R5 not yet", {29'b0, irq}, 0);
        @(posedge clk);
        @(negedge clk); chk("R5 R7 irq on third edge", {29'b0, irq}, 3'b010);
        rd(8'h24, rv); chk("R5 falling only", rv, 32'h30);
        @(negedge clk); pin_in[15:8] = 8'hFF;
        repeat (4) @(posedge clk);
        rd(8'h24, rv); chk("R5 rising adds", rv, 32'h3F);
        wr(8'h28, 32'h00);
        @(negedge clk); chk("R7 masked", {29'b0, irq}, 0);
        rd(8'h24, rv); chk("R7 event kept", rv, 32'h3F);
        wr(8'h24, 32'h3F);
        rd(8'h24, rv); chk("R6 ack clears", rv, 0);
    endtask

    task automatic t_force;
        wr(8'h48, 32'h81);
        rd(8'h40, rv); chk("R6 force sets", rv, 32'h81);
        rd(8'h48, rv); chk("R6 force reads 0", rv, 0);
        wr(8'h44, 32'h01);
        @(negedge clk); chk("R7 port2 irq", {29'b0, irq}, 3'b100);
        wr(8'h40, 32'h01);
        @(negedge clk); chk("R7 irq drops", {29'b0, irq}, 0);
        rd(8'h40, rv); chk("R6 partial ack", rv, 32'h80);
    endtask

    task automatic t_pull;
        wr(8'h50, 32'hF0);
        @(negedge clk); chk("R8 pull disable", {24'b0, pin_pull_en[23:16]}, 32'h0F);
        chk("R8 others", {16'b0, pin_pull_en[15:0]}, 32'hFFFF);
    endtask

    task automatic t_unmapped;
        rd(8'h58, rv); chk("R10 beyond map", rv, 0);
        rd(8'h1E, rv); chk("R10 unaligned", rv, 0);
        wr(8'h22, 32'hFFFF);
        rd(8'h20, rv); chk("R10 unaligned write", rv, 0);
        wr(8'h56, 32'h0);
        rd(8'h54, rv); chk("R10 ctrl intact", rv, 1);
    endtask

    task automatic t_hold;
        wr(8'h04, 32'h5555); wr(8'h00, 32'hFF);
        wr(8'h08, 32'hFF);
        wr(8'h54, 32'h0);
        wr(8'h00, 32'h00);
        @(negedge clk); chk("R9 output held", {24'b0, pin_out[7:0]}, 32'hFF);
        @(negedge clk); pin_in[7:0] = 8'h00;
        repeat (4) @(posedge clk);
        wr(8'h10, 32'h01);
        rd(8'h08, rv); chk("R9 no event while off", rv, 0);
        wr(8'h54, 32'h1);
        repeat (3) @(posedge clk);
        rd(8'h08, rv); chk("R9 no event after re-enable", rv, 0);
        rd(8'h00, rv); chk("R9 read works", rv, 0);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0;
        bus_wdata = '0; pin_in = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset;
        t_disabled_writes;
        t_data;
        t_drive;
        t_edge;
        t_force;
        t_pull;
        t_unmapped;
        t_hold;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule